// File: doc/BRIEF.md
# Instruction Fetch Next-PC Unit

This block owns the program counter of a simple in-order pipeline. It presents the counter as the fetch address to a synchronous instruction memory whose read data appears one clock after the address. It returns one 32-bit instruction per cycle, together with the address that instruction came from and a valid flag. The next address is worked out in the same cycle as the memory read.

Three sources compete for the next address. An exception redirect loads a fixed handler vector. A taken branch or jump loads its computed target. Otherwise the counter steps forward by one 4-byte instruction. An exception wins over a branch, and a branch wins over the sequential step.

A stall from the pipeline freezes the counter and the returned instruction. The unit keeps a one-entry copy of the memory data so that the returned instruction stays put while the memory keeps reading. A branch issued in a cycle does not squash the fetch already in flight (delay-slot behaviour). An exception marks the in-flight fetch invalid.

Top module: `ifetch_npc`

## Requirements
- R1: During reset and in the first cycle after it, the fetch address equals the RESET_VEC parameter (low two bits cleared) and the valid flag is 0.
- R2: With no stall, no branch and no exception, the fetch address on the next cycle is the current fetch address plus 4.
- R3: A taken branch without stall or exception makes the fetch address on the next cycle equal to the branch target with its two low bits cleared.
- R4: An exception request makes the fetch address on the next cycle equal to the EXC_VEC parameter, whatever the branch and stall inputs are.
- R5: While stall is 1 and no exception is requested, the fetch address, the returned instruction, its address and the valid flag all hold their values, and a taken branch in that cycle has no effect.
- R6: The two low bits of the fetch address are always 0.
- R7: A cycle with neither stall nor exception makes the next cycle's valid flag 1 and the returned instruction address equal to this cycle's fetch address. This includes the instruction fetched in the cycle a branch is taken.
- R8: An exception request makes the valid flag 0 in the following cycle. The instruction fetched at the handler vector returns valid one cycle later.
- R9: When the valid flag is 1, the returned instruction is the memory word at the returned instruction address. This holds after a stall is released as well.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Freeze the counter and the returned instruction |
| jump_take_i | input | 1 | A branch or jump is taken this cycle |
| jump_tgt_i | input | 32 | Target address for the taken branch or jump |
| trap_req_i | input | 1 | Exception redirect to the handler vector |
| imem_addr_o | output | 32 | Fetch address to the instruction memory |
| imem_rdata_i | input | 32 | Memory data, one cycle after the address |
| inst_o | output | 32 | Returned instruction |
| inst_pc_o | output | 32 | Address of the returned instruction |
| inst_valid_o | output | 1 | Returned instruction is valid |

## Verification
The bench raises an exception and a branch in the same cycle. A design with the priority reversed would land on the branch target instead of the handler vector. It holds a stall for several cycles and then releases it. A design that passes memory data straight through would show the instruction at the held address during the stall, and one that dropped the held data would return the wrong word on release. Further cases cover a branch during a stall, which a wrong design would take; an exception during a stall, which a wrong design would block; and a misaligned branch target, which would leak into the low address bits. It also checks the delay-slot instruction after a branch, which would go missing if a branch squashed the in-flight fetch.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;

    localparam int unsigned ADDR_W     = 32;
    localparam int unsigned INSN_W     = 32;
    localparam int unsigned INSN_BYTES = 4;
    localparam int unsigned ALIGN_BITS = $clog2(INSN_BYTES);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [INSN_W-1:0] insn_t;

    // where the next fetch address comes from
    typedef enum logic [1:0] {
        SRC_SEQ    = 2'd0,
        SRC_BRANCH = 2'd1,
        SRC_TRAP   = 2'd2,
        SRC_HOLD   = 2'd3
    } npc_src_e;

    // tag of the fetch whose data is returning from memory
    typedef struct packed {
        logic  valid;
        addr_t pc;
    } fetch_tag_t;

    function automatic addr_t word_align(input addr_t a);
        addr_t r;
        r = a;
        r[ALIGN_BITS-1:0] = '0;
        return r;
    endfunction

    function automatic addr_t seq_next(input addr_t a);
        return a + addr_t'(INSN_BYTES);
    endfunction

endpackage

// File: rtl/npc_select.sv
module npc_select
    import ifetch_pkg::*;
(
    input  addr_t    pc_i,
    input  logic     stall_i,
    input  logic     jump_take_i,
    input  addr_t    jump_tgt_i,
    input  logic     trap_req_i,
    input  addr_t    trap_vec_i,
    output addr_t    npc_o,
    output npc_src_e src_o
);

    // fixed priority: exception, stall, branch, sequential
    always_comb begin
        if (trap_req_i) begin
            src_o = SRC_TRAP;
            npc_o = word_align(trap_vec_i);
        end else if (stall_i) begin
            src_o = SRC_HOLD;
            npc_o = pc_i;
        end else if (jump_take_i) begin
            src_o = SRC_BRANCH;
            npc_o = word_align(jump_tgt_i);
        end else begin
            src_o = SRC_SEQ;
            npc_o = seq_next(pc_i);
        end
    end

endmodule

// File: rtl/pc_reg.sv
module pc_reg
    import ifetch_pkg::*;
#(
    parameter addr_t RESET_VEC = 32'h0000_0100
) (
    input  logic  clk,
    input  logic  rst,
    input  addr_t npc_i,
    output addr_t pc_o
);

    localparam addr_t BOOT_PC = word_align(RESET_VEC);

    addr_t pc_q;

    always_ff @(posedge clk) begin
        if (rst) pc_q <= BOOT_PC;
        else     pc_q <= npc_i;
    end

    assign pc_o = pc_q;

endmodule

// File: rtl/fetch_resp.sv
module fetch_resp
    import ifetch_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  npc_src_e src_i,
    input  addr_t    pc_i,
    input  insn_t    rdata_i,
    output insn_t    inst_o,
    output addr_t    inst_pc_o,
    output logic     inst_valid_o
);

    fetch_tag_t tag_q;
    insn_t      keep_q;
    logic       keep_vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q      <= '0;
            keep_q     <= '0;
            keep_vld_q <= 1'b0;
        end else begin
            unique case (src_i)
                SRC_TRAP: begin
                    // the in-flight fetch is squashed
                    tag_q.valid <= 1'b0;
                    tag_q.pc    <= pc_i;
                    keep_vld_q  <= 1'b0;
                end
                SRC_HOLD: begin
                    // memory keeps re-reading; capture the word on show once
                    if (!keep_vld_q) begin
                        keep_q     <= rdata_i;
                        keep_vld_q <= 1'b1;
                    end
                end
                default: begin
                    // sequential or branch: current fetch returns next cycle
                    tag_q.valid <= 1'b1;
                    tag_q.pc    <= pc_i;
                    keep_vld_q  <= 1'b0;
                end
            endcase
        end
    end

    assign inst_o       = keep_vld_q ? keep_q : rdata_i;
    assign inst_pc_o    = tag_q.pc;
    assign inst_valid_o = tag_q.valid;

endmodule

// File: rtl/ifetch_npc.sv
module ifetch_npc
    import ifetch_pkg::*;
#(
    parameter addr_t RESET_VEC = 32'h0000_0100,
    parameter addr_t EXC_VEC   = 32'h0000_0080
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 stall_i,
    input  logic                 jump_take_i,
    input  logic [ADDR_W-1:0]    jump_tgt_i,
    input  logic                 trap_req_i,
    output logic [ADDR_W-1:0]    imem_addr_o,
    input  logic [INSN_W-1:0]    imem_rdata_i,
    output logic [INSN_W-1:0]    inst_o,
    output logic [ADDR_W-1:0]    inst_pc_o,
    output logic                 inst_valid_o
);

    addr_t    pc;
    addr_t    npc;
    npc_src_e src;

    npc_select u_sel (
        .pc_i        (pc),
        .stall_i     (stall_i),
        .jump_take_i (jump_take_i),
        .jump_tgt_i  (jump_tgt_i),
        .trap_req_i  (trap_req_i),
        .trap_vec_i  (EXC_VEC),
        .npc_o       (npc),
        .src_o       (src)
    );

    pc_reg #(.RESET_VEC(RESET_VEC)) u_pc (
        .clk   (clk),
        .rst   (rst),
        .npc_i (npc),
        .pc_o  (pc)
    );

    fetch_resp u_resp (
        .clk          (clk),
        .rst          (rst),
        .src_i        (src),
        .pc_i         (pc),
        .rdata_i      (imem_rdata_i),
        .inst_o       (inst_o),
        .inst_pc_o    (inst_pc_o),
        .inst_valid_o (inst_valid_o)
    );

    assign imem_addr_o = pc;

endmodule

// File: rtl/ifetch_npc_chk.sv
module ifetch_npc_chk
    import ifetch_pkg::*;
#(
    parameter addr_t RESET_VEC = 32'h0000_0100,
    parameter addr_t EXC_VEC   = 32'h0000_0080
) (
    input logic  clk,
    input logic  rst,
    input logic  stall_i,
    input logic  jump_take_i,
    input addr_t jump_tgt_i,
    input logic  trap_req_i,
    input addr_t imem_addr_o,
    input insn_t inst_o,
    input addr_t inst_pc_o,
    input logic  inst_valid_o
);

    localparam addr_t BOOT_PC = word_align(RESET_VEC);
    localparam addr_t TRAP_PC = word_align(EXC_VEC);

    p_boot_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (imem_addr_o == BOOT_PC && !inst_valid_o));

    p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
        (!stall_i && !jump_take_i && !trap_req_i)
        |=> imem_addr_o == $past(imem_addr_o) + 32'd4);

    p_branch_tgt_r3: assert property (@(posedge clk) disable iff (rst)
        (jump_take_i && !stall_i && !trap_req_i)
        |=> imem_addr_o == word_align($past(jump_tgt_i)));

    p_trap_first_r4: assert property (@(posedge clk) disable iff (rst)
        trap_req_i |=> imem_addr_o == TRAP_PC);

    p_stall_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (stall_i && !trap_req_i)
        |=> ($stable(imem_addr_o) && $stable(inst_o)
             && $stable(inst_pc_o) && $stable(inst_valid_o)));

    p_word_aligned_r6: assert property (@(posedge clk) disable iff (rst)
        imem_addr_o[1:0] == 2'b00);

    p_tag_follows_r7: assert property (@(posedge clk) disable iff (rst)
        (!stall_i && !trap_req_i)
        |=> (inst_valid_o && inst_pc_o == $past(imem_addr_o)));

    p_trap_squash_r8: assert property (@(posedge clk) disable iff (rst)
        trap_req_i |=> !inst_valid_o);

endmodule

bind ifetch_npc ifetch_npc_chk #(
    .RESET_VEC (RESET_VEC),
    .EXC_VEC   (EXC_VEC)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .stall_i      (stall_i),
    .jump_take_i  (jump_take_i),
    .jump_tgt_i   (jump_tgt_i),
    .trap_req_i   (trap_req_i),
    .imem_addr_o  (imem_addr_o),
    .inst_o       (inst_o),
    .inst_pc_o    (inst_pc_o),
    .inst_valid_o (inst_valid_o)
);

// File: tb/sim_ifetch_npc.sv
`timescale 1ns/1ps
module sim_ifetch_npc;

    localparam logic [31:0] RV = 32'h0000_0100;
    localparam logic [31:0] EV = 32'h0000_0080;
    localparam int          WATCHDOG_CYC = 2000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stall = 1'b0;
    logic        jt = 1'b0;
    logic [31:0] jtgt = '0;
    logic        trap = 1'b0;
    logic [31:0] addr;
    logic [31:0] rdata = '0;
    logic [31:0] inst;
    logic [31:0] ipc;
    logic        ivld;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [31:0] mem [64];

    always #2.5 clk = ~clk;

    function automatic logic [31:0] exp_insn(input logic [31:0] a);
        return 32'h1300_0000 | {18'd0, a[7:2], 8'd0} | {26'd0, a[7:2]};
    endfunction

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = exp_insn(32'(i) << 2);
    end

    // synchronous memory: data one clock after the address
    always @(posedge clk) rdata <= mem[addr[7:2]];

    ifetch_npc #(.RESET_VEC(RV), .EXC_VEC(EV)) u0 (
        .clk          (clk),
        .rst          (rst),
        .stall_i      (stall),
        .jump_take_i  (jt),
        .jump_tgt_i   (jtgt),
        .trap_req_i   (trap),
        .imem_addr_o  (addr),
        .imem_rdata_i (rdata),
        .inst_o       (inst),
        .inst_pc_o    (ipc),
        .inst_valid_o (ivld)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step();
        step();
        chk("R1 addr in reset", addr, RV);
        chk("R1 valid in reset", 32'(ivld), 0);
        rst = 1'b0;
        chk("R1 addr after reset", addr, RV);
        step();
        chk("R7 first valid", 32'(ivld), 1);
        chk("R7 first pc", ipc, RV);
        chk("R9 first insn", inst, exp_insn(RV));
        chk("R2 first step", addr, RV + 4);
    endtask

    task automatic t_sequential();
        for (int k = 0; k < 5; k++) begin
            logic [31:0] p;
            p = addr;
            step();
            chk("R2 seq addr", addr, p + 4);
            chk("R7 seq pc", ipc, p);
            chk("R9 seq insn", inst, exp_insn(p));
            chk("R6 seq aligned", 32'(addr[1:0]), 0);
        end
    endtask

    task automatic t_branch(input logic [31:0] tgt);
        logic [31:0] p;
        logic [31:0] t;
        p = addr;
        t = {tgt[31:2], 2'b00};
        jt = 1'b1;
        jtgt = tgt;
        step();
        jt = 1'b0;
        chk("R3 branch addr", addr, t);
        chk("R6 branch aligned", 32'(addr[1:0]), 0);
        chk("R7 delay slot valid", 32'(ivld), 1);
        chk("R7 delay slot pc", ipc, p);
        step();
        chk("R9 target insn", inst, exp_insn(t));
        chk("R7 target pc", ipc, t);
        chk("R2 after branch", addr, t + 4);
    endtask

    task automatic t_trap_over_branch();
        trap = 1'b1;
        jt = 1'b1;
        jtgt = 32'h0000_0040;
        step();
        trap = 1'b0;
        jt = 1'b0;
        chk("R4 trap wins", addr, EV);
        chk("R8 squash", 32'(ivld), 0);
        step();
        chk("R8 handler valid", 32'(ivld), 1);
        chk("R8 handler pc", ipc, EV);
        chk("R9 handler insn", inst, exp_insn(EV));
    endtask

    task automatic t_stall();
        logic [31:0] p;
        logic [31:0] q;
        p = addr;
        q = ipc;
        stall = 1'b1;
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R5 stall addr", addr, p);
            chk("R5 stall pc", ipc, q);
            chk("R5 stall insn", inst, exp_insn(q));
            chk("R5 stall valid", 32'(ivld), 1);
        end
        // branch during stall has no effect
        jt = 1'b1;
        jtgt = 32'h0000_0020;
        step();
        jt = 1'b0;
        chk("R5 branch ignored addr", addr, p);
        chk("R5 branch ignored insn", inst, exp_insn(q));
        stall = 1'b0;
        step();
        chk("R9 release pc", ipc, p);
        chk("R9 release insn", inst, exp_insn(p));
        chk("R2 release addr", addr, p + 4);
    endtask

    task automatic t_trap_in_stall();
        stall = 1'b1;
        step();
        trap = 1'b1;
        step();
        trap = 1'b0;
        stall = 1'b0;
        chk("R4 trap through stall", addr, EV);
        chk("R8 squash in stall", 32'(ivld), 0);
        step();
        chk("R8 handler after stall", ipc, EV);
        chk("R9 handler insn after stall", inst, exp_insn(EV));
    endtask

    initial begin
        #1;
        t_reset();
        t_sequential();
        t_branch(32'h0000_0010);
        t_sequential();
        t_branch(32'h0000_01F3);
        t_trap_over_branch();
        t_stall();
        t_trap_in_stall();
        t_sequential();
        t_reset();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule